// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes every instruction in one clock period. It fetches a word from a local instruction memory and decodes it. It reads two operands from a 32 x 32-bit register file and runs them through an adder/subtractor/OR unit. It may read or write a local data memory, and it writes the result back. All of this happens inside one period, and every piece of state commits on the falling clock edge. The core executes seven operations: add, subtract, OR with a zero-extended immediate, word load, word store, branch-if-equal and absolute jump.

Both memories are word arrays with combinational read. The instruction memory has no write path in the design and is filled by the surrounding environment before reset is released. Apart from clock and reset, the only ports are a debug view. It shows the address of the instruction now executing and the register write that instruction will commit at the next falling edge.

Top module: `mono_cycle_cpu`

## Requirements
- R1: Reset is synchronous and active high, and it is sampled on the falling edge. While it is applied, the PC becomes 0 and all 32 registers become 0. Nothing is written to memory while reset is applied.
- R2: The PC, the register file and the data memory change only on the falling edge. Between falling edges, `dbg_pc` shows the current instruction address. `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show that instruction's pending register write. Any instruction other than a taken branch or a jump moves the PC forward by 4.
- R3: An R-type word has opcode 0 (bits 31:26), rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11. A funct value (bits 5:0) of 0x20 or 0x21 writes R[rs]+R[rt] to rd. A funct value of 0x22 or 0x23 writes R[rs]-R[rt] to rd. Both wrap modulo 2^32.
- R4: Opcode 0x0D writes R[rs] OR {16'b0, imm16} to rt, where imm16 is bits 15:0.
- R5: Opcode 0x23 loads rt from the data word at byte address R[rs]+sign_ext(imm16), indexed by address bits above bit 1. Opcode 0x2B stores R[rt] to the same address and raises no register write.
- R6: Opcode 0x04 subtracts R[rt] from R[rs]. When the difference is zero, the next PC is PC+4+(sign_ext(imm16)<<2). Otherwise it is PC+4. No register is written.
- R7: Opcode 0x02 sets the PC to {PC+4 bits 31:28, bits 25:0, 2'b00}. No register is written.
- R8: Register 0 always reads as zero. A write aimed at it is shown on the debug port but leaves its value at zero.
- R9: Any other opcode, and an R-type word whose funct is outside 0x20 to 0x23, writes nothing and moves the PC forward by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state commits on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Byte address of the instruction now executing |
| dbg_wr_en | output | 1 | Current instruction writes a register |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value to be written |

## Verification
Each cycle's debug values come straight from the current PC and register contents. So a corrupted register, a wrong memory word or a misdirected PC shows up as soon as an instruction consumes it. A bad register or memory word appears in the write data of the next instruction that reads it. A bad next-PC appears on `dbg_pc` one period later. The program mixes directed control-flow cases with random arithmetic and memory traffic, so that wrong values propagate quickly to the write port.

// File: rtl/mono_cycle_cpu.sv
module mono_cycle_cpu #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_addr,
  output logic [31:0] dbg_wr_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam logic [5:0] OP_RT = 6'h00, OP_ORI = 6'h0D, OP_LD = 6'h23,
                         OP_ST = 6'h2B, OP_BEQ = 6'h04, OP_JMP = 6'h02;

  logic [31:0] pc;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf [32];

  initial for (int i = 0; i < IMEM_WORDS; i++) imem[i] = 32'h0;

  logic [31:0] instr;
  logic [5:0]  op;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  assign instr = imem[pc[IAW+1:2]];
  assign op  = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign imm = instr[15:0];

  logic is_rt, rt_ok, is_ori, is_ld, is_st, is_beq, is_jmp;
  assign is_rt  = op == OP_RT;
  assign rt_ok  = is_rt && instr[5:2] == 4'b1000;
  assign is_ori = op == OP_ORI;
  assign is_ld  = op == OP_LD;
  assign is_st  = op == OP_ST;
  assign is_beq = op == OP_BEQ;
  assign is_jmp = op == OP_JMP;

  logic sel_rd, sel_imm, sign_ext, from_mem, reg_we, mem_we, do_sub, do_or;
  assign sel_rd   = is_rt;
  assign sel_imm  = is_ori | is_ld | is_st;
  assign sign_ext = is_ld | is_st | is_beq;
  assign from_mem = is_ld;
  assign reg_we   = rt_ok | is_ori | is_ld;
  assign mem_we   = is_st;
  assign do_sub   = is_beq | (is_rt & instr[1]);
  assign do_or    = is_ori;

  logic [31:0] ext, bus_a, bus_b, opnd_b, alu_res, mem_rd, wb_data;
  logic [4:0]  wb_addr;
  logic        zero;
  assign ext     = sign_ext ? {{16{imm[15]}}, imm} : {16'h0, imm};
  assign bus_a   = rf[rs];
  assign bus_b   = rf[rt];
  assign opnd_b  = sel_imm ? ext : bus_b;
  assign alu_res = do_or ? (bus_a | opnd_b) : do_sub ? (bus_a - opnd_b) : (bus_a + opnd_b);
  assign zero    = alu_res == 32'h0;
  assign mem_rd  = dmem[alu_res[DAW+1:2]];
  assign wb_data = from_mem ? mem_rd : alu_res;
  assign wb_addr = sel_rd ? rd : rt;

  logic [31:0] pc4, br_tgt, jmp_tgt, next_pc;
  assign pc4     = pc + 32'd4;
  assign br_tgt  = pc4 + (ext << 2);
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};
  assign next_pc = is_jmp ? jmp_tgt : (is_beq && zero) ? br_tgt : pc4;

  always_ff @(negedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'h0;
    end else if (reg_we && wb_addr != 5'd0) begin
      rf[wb_addr] <= wb_data;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst && mem_we) dmem[alu_res[DAW+1:2]] <= bus_b;
  end

  assign dbg_pc      = pc;
  assign dbg_wr_en   = reg_we;
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;
endmodule

// File: rtl/cpu_props.sv
module cpu_props (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] bus_a,
  input logic [31:0] bus_b,
  input logic [31:0] rf_zero,
  input logic        wr_en
);
  logic [5:0]  op;
  logic [31:0] pc4, sext, br_tgt, jmp_tgt;
  assign op      = instr[31:26];
  assign pc4     = pc + 32'd4;
  assign sext    = {{16{instr[15]}}, instr[15:0]};
  assign br_tgt  = pc4 + {sext[29:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

  // R2
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04 && op != 6'h02) |=> pc == $past(pc4));

  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && bus_a == bus_b) |=> pc == $past(br_tgt));

  // R6
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && bus_a != bus_b) |=> pc == $past(pc4));

  // R7
  jmp_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'h02 |=> pc == $past(jmp_tgt));

  // R5
  store_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'h2B |-> !wr_en);

  // R8
  reg_zero_chk: assert property (@(posedge clk) disable iff (rst) rf_zero == 32'h0);
endmodule

bind mono_cycle_cpu cpu_props u_props (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .bus_a(bus_a), .bus_b(bus_b), .rf_zero(rf[0]), .wr_en(dbg_wr_en)
);

// File: tb/sim_mono_cycle_cpu.sv
module sim_mono_cycle_cpu;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int HALT_IDX = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic dbg_wr_en;
  logic [4:0] dbg_wr_addr;

  always #2 clk = ~clk;

  mono_cycle_cpu #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data));

  int n_chk = 0, n_bad = 0;
  logic [31:0] prog [IW];
  logic [31:0] mreg [32];
  logic [31:0] mmem [DW];
  bit          written [DW];
  logic [31:0] mpc;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] o, int s, int t, logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, output bit we, output logic [4:0] wa,
                      output logic [31:0] wd, output logic [31:0] nxt, output string tag);
    logic [5:0] o = ins[31:26];
    logic [31:0] a = mreg[ins[25:21]];
    logic [31:0] b = mreg[ins[20:16]];
    logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] ad = a + se;
    we = 0; wa = ins[20:16]; wd = 32'h0; nxt = mpc + 4; tag = "R9";
    case (o)
      6'h00: begin
        wa = ins[15:11];
        if (ins[5:2] == 4'b1000) begin
          we = 1; tag = "R3";
          wd = ins[1] ? a - b : a + b;
        end else wd = a + b;
      end
      6'h0D: begin we = 1; tag = "R4"; wd = a | {16'h0, ins[15:0]}; end
      6'h23: begin we = 1; tag = "R5"; wd = mmem[ad[7:2]]; end
      6'h2B: begin tag = "R5"; mmem[ad[7:2]] = b; end
      6'h04: begin tag = "R6"; if (a == b) nxt = mpc + 4 + (se << 2); end
      6'h02: begin tag = "R7"; nxt = {nxt[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (we && wa != 0) mreg[wa] = wd;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    bit we; logic [4:0] wa; logic [31:0] wd, nxt, ins;
    string tag, pc_tag;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
    prog[1]  = enc_i(6'h0D, 0, 0, 16'h1234);
    prog[2]  = enc_r(0, 2, 3, 6'h21);
    prog[3]  = enc_r(0, 2, 4, 6'h23);
    prog[4]  = enc_i(6'h2B, 0, 4, 16'h0008);
    prog[5]  = enc_i(6'h23, 0, 5, 16'h0008);
    prog[6]  = enc_i(6'h0D, 0, 6, 16'h0040);
    prog[7]  = enc_i(6'h23, 6, 7, 16'hFFC8);
    prog[8]  = enc_i(6'h04, 3, 4, 16'h0005);
    prog[9]  = enc_i(6'h04, 5, 7, 16'h0001);
    prog[10] = enc_i(6'h0D, 0, 8, 16'h0BAD);
    prog[11] = {6'h02, 26'd13};
    prog[12] = enc_i(6'h0D, 0, 9, 16'h0BAD);
    prog[13] = enc_r(4, 2, 10, 6'h20);
    prog[14] = enc_i(6'h3F, 1, 12, 16'h7777);
    prog[15] = enc_r(2, 3, 11, 6'h25);
    for (int k = 0; k < DW; k++) written[k] = 0;
    written[2] = 1;
    for (int k = 16; k < HALT_IDX; k++) begin
      int kind = int'($urandom % 5);
      int s = int'($urandom % 16), t = int'($urandom % 16), d = int'($urandom % 16);
      int w = int'($urandom % DW);
      case (kind)
        0: prog[k] = enc_r(s, t, d, 6'h21);
        1: prog[k] = enc_r(s, t, d, 6'h23);
        2: prog[k] = enc_i(6'h0D, s, t, 16'($urandom));
        3: begin prog[k] = enc_i(6'h2B, 0, t, 16'(w * 4)); written[w] = 1; end
        default: begin
          int r = w;
          for (int q = 0; q < DW && !written[r]; q++) r = (r + 1) % DW;
          prog[k] = enc_i(6'h23, 0, t, 16'(r * 4));
        end
      endcase
    end
    prog[HALT_IDX] = enc_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < IW; i++) u0.imem[i] = prog[i];
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    for (int i = 0; i < DW; i++) mmem[i] = 32'h0;
    mpc = 32'h0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", dbg_pc, 32'h0);
    pc_tag = "R2";
    for (int cyc = 0; cyc < 90; cyc++) begin
      ins = prog[mpc[7:2]];
      chk({pc_tag, " pc"}, dbg_pc, mpc);
      step(ins, we, wa, wd, nxt, tag);
      if (cyc == 2) tag = "R8";
      chk({tag, " wr_en"}, {31'h0, dbg_wr_en}, {31'h0, we});
      if (we) begin
        chk({tag, " wr_addr"}, {27'h0, dbg_wr_addr}, {27'h0, wa});
        chk({tag, " wr_data"}, dbg_wr_data, wd);
      end
      pc_tag = (tag == "R6" || tag == "R7") ? tag : "R2";
      mpc = nxt;
      rst = 1'b0;
      @(posedge clk);
      #1;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule